// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a system watchdog with two clock domains. A small register file sits on a fast bus clock. A down-counter runs on a slow, free-running clock that keeps going when the bus clock is slowed or stopped. Software controls the block through 16-bit key codes written to a key register. One code opens the configuration registers for writing. One code starts the counter and closes the configuration again. One code refreshes the counter. Any other value closes the configuration.

The configuration has three fields. A 3-bit divider select sets the counter clock to the slow clock divided by four shifted left by the field. A 12-bit reload value is the count loaded on start and on every refresh. A 12-bit window value is the highest count at which a refresh is still accepted. Every change to these fields, and every start or refresh command, reaches the slow domain through a two-flop toggle handshake. A status register shows, one bit per field, which transfers have not yet been acknowledged. While a field's transfer is pending, writes to that field are ignored.

The block emits a reset pulse one slow-clock cycle wide in two cases: the count reaches zero, or a refresh arrives while the count is still above the window value. After a pulse the counter reloads and keeps running. Once started, only the reset inputs can stop it.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the divider select reads 0, the reload and window registers read 4095, the status register reads 0, the key register reads 0, and no reset pulse is produced.
- R2: Writes to the divider select (address 1), reload (address 2) and window (address 3) registers are ignored while configuration is locked. Configuration is locked after reset, after a start key, and after any key value other than 0x5555 or 0xAAAA.
- R3: Writing 0x5555 to the key register (address 0) unlocks configuration. Writes then store the low 3 bits of the divider select and the low 12 bits of the reload and window values, which read back at the same addresses.
- R4: The status register (address 4) has bit 0 for the divider select, bit 1 for reload and bit 2 for window. A bit reads 1 from the bus cycle after an accepted write until the slow domain acknowledges the transfer, and then returns to 0.
- R5: A write to a configuration register whose status bit is set is ignored. The register keeps the value whose transfer is pending.
- R6: Writing 0xCCCC to the key register starts the counter from the reload value and locks configuration.
- R7: Once the counter is running, it decrements once every 4<<S slow cycles, where S is the divider select. When a decrement is due at a count of zero, the block emits a reset pulse exactly one slow cycle wide and reloads. Consecutive timeout pulses are therefore (reload+1)*(4<<S) slow cycles apart.
- R8: Writing 0xAAAA to the key register reloads the counter. Refreshes issued more often than the timeout period prevent any reset pulse.
- R9: A refresh that arrives while the count is greater than the window value produces a reset pulse. A refresh at or below the window value does not.
- R10: A running counter cannot be stopped by any key write. It keeps producing periodic timeout pulses.
- R11: A refresh key written before the counter has been started has no effect: no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register address: 0 key, 1 divider select, 2 reload, 3 window, 4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| slow_clk | input | 1 | Free-running low-speed counter clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| wdt_rst_pulse | output | 1 | System reset request, one slow cycle wide |

## Verification
The embedded assertions check these properties on every clock cycle: configuration writes leave the stored values unchanged while locked or while their transfer is pending, a stray key value relocks, the counter never stops once running, each due decrement lowers the count by one, a zero-count decrement always yields a pulse, and a stopped counter never pulses. The bench's scenarios are needed for everything that depends on the two clocks running together. These are the exact period between timeout pulses for every divider select, the busy flag rising and clearing across the handshake, the pulse width, and the early-refresh outcome on either side of the window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W      = 16;
  localparam int ADDR_W     = 3;
  localparam int SEL_W      = 3;
  localparam int COUNT_W    = 12;

  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RUN     = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_KICK    = 16'hAAAA;

  localparam logic [ADDR_W-1:0] A_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_WINDOW = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam int F_SEL    = 0;
  localparam int F_RELOAD = 1;
  localparam int F_WINDOW = 2;
  localparam int N_FIELDS = 3;

  // slow cycles per counter decrement for a given divider select
  function automatic int unsigned tick_div(input int unsigned sel);
    return 32'd4 << sel;
  endfunction

  // slow cycles between two consecutive timeout pulses
  function automatic int unsigned timeout_period(input int unsigned sel,
                                                 input int unsigned reload);
    return (reload + 1) * tick_div(sel);
  endfunction
endpackage

// File: rtl/wdt_tsync.sv
module wdt_tsync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl
);
  logic [W-1:0] meta, hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      hold <= '0;
    end else begin
      meta <= d;
      hold <= meta;
    end
  end

  assign lvl = hold;
endmodule

// File: rtl/wdt_bus_if.sv
module wdt_bus_if
  import wdt_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = COUNT_W,
  parameter int KW = KEY_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [KW-1:0] wdata,
  output logic [KW-1:0] rdata,
  input  logic [N_FIELDS-1:0] ack_lvl,
  output logic [N_FIELDS-1:0] req_t,
  output logic          run_t,
  output logic          kick_t,
  output logic [SW-1:0] sel_sh,
  output logic [CW-1:0] reload_sh,
  output logic [CW-1:0] window_sh
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic unlocked;
  logic [N_FIELDS-1:0] busy;
  logic key_wr, key_open, key_run, key_kick, key_other;
  logic [N_FIELDS-1:0] field_hit, field_take;

  assign busy      = req_t ^ ack_lvl;
  assign key_wr    = wr && (addr == A_KEY);
  assign key_open  = key_wr && (wdata == KEY_OPEN);
  assign key_run   = key_wr && (wdata == KEY_RUN);
  assign key_kick  = key_wr && (wdata == KEY_KICK);
  assign key_other = key_wr && !key_open && !key_kick;

  assign field_hit[F_SEL]    = wr && (addr == A_SEL);
  assign field_hit[F_RELOAD] = wr && (addr == A_RELOAD);
  assign field_hit[F_WINDOW] = wr && (addr == A_WINDOW);

  genvar gi;
  generate
    for (gi = 0; gi < N_FIELDS; gi++) begin : g_take
      assign field_take[gi] = field_hit[gi] && unlocked && !busy[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (key_open) begin
      unlocked <= 1'b1;
    end else if (key_other) begin
      unlocked <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh    <= '0;
      reload_sh <= CNT_MAX;
      window_sh <= CNT_MAX;
      req_t     <= '0;
      run_t     <= 1'b0;
      kick_t    <= 1'b0;
    end else begin
      if (field_take[F_SEL])    sel_sh    <= wdata[SW-1:0];
      if (field_take[F_RELOAD]) reload_sh <= wdata[CW-1:0];
      if (field_take[F_WINDOW]) window_sh <= wdata[CW-1:0];
      req_t <= req_t ^ field_take;
      if (key_run)  run_t  <= ~run_t;
      if (key_kick) kick_t <= ~kick_t;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_SEL:    rdata[SW-1:0] = sel_sh;
      A_RELOAD: rdata[CW-1:0] = reload_sh;
      A_WINDOW: rdata[CW-1:0] = window_sh;
      A_STATUS: rdata[N_FIELDS-1:0] = busy;
      default:  rdata = '0;
    endcase
  end

  assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_hit[F_RELOAD] && !unlocked) |=> $stable(reload_sh));

  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_hit[F_WINDOW] && busy[F_WINDOW]) |=> $stable(window_sh));

  assert_stray_key_relocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_other |=> !unlocked);

  assert_start_relocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_run |=> !unlocked);
endmodule

// File: rtl/wdt_slow_core.sv
module wdt_slow_core
  import wdt_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = COUNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_FIELDS-1:0] req_lvl,
  input  logic                run_lvl,
  input  logic                kick_lvl,
  input  logic [SW-1:0]       sel_d,
  input  logic [CW-1:0]       reload_d,
  input  logic [CW-1:0]       window_d,
  output logic [N_FIELDS-1:0] ack_t,
  output logic                pulse
);
  localparam int MAX_SEL = (1 << SW) - 1;
  localparam int PW      = $clog2(4 << MAX_SEL);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [N_FIELDS-1:0] req_prev, req_chg;
  logic run_prev, kick_prev, run_evt, kick_evt;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] reload_q, window_q, cnt;
  logic [PW-1:0] pcnt, pcnt_last;
  logic running, tick, early, expire, fire, reload_now, count_step;

  assign req_chg  = req_lvl ^ req_prev;
  assign run_evt  = run_lvl ^ run_prev;
  assign kick_evt = kick_lvl ^ kick_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev  <= '0;
      run_prev  <= 1'b0;
      kick_prev <= 1'b0;
    end else begin
      req_prev  <= req_lvl;
      run_prev  <= run_lvl;
      kick_prev <= kick_lvl;
    end
  end

  // configuration capture and acknowledge, one flop set per field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      reload_q <= CNT_MAX;
      window_q <= CNT_MAX;
      ack_t    <= '0;
    end else begin
      if (req_chg[F_SEL])    sel_q    <= sel_d;
      if (req_chg[F_RELOAD]) reload_q <= reload_d;
      if (req_chg[F_WINDOW]) window_q <= window_d;
      ack_t <= ack_t ^ req_chg;
    end
  end

  assign pcnt_last  = PW'(tick_div(32'(sel_q)) - 1);
  assign tick       = running && (pcnt == pcnt_last);
  assign expire     = tick && (cnt == '0);
  assign early      = running && kick_evt && (cnt > window_q);
  assign fire       = expire || early;
  assign reload_now = fire || (running && kick_evt) || (!running && run_evt);
  assign count_step = tick && !reload_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= CNT_MAX;
      pcnt    <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= fire;
      if (run_evt) running <= 1'b1;
      if (reload_now) begin
        cnt  <= reload_q;
        pcnt <= '0;
      end else if (tick) begin
        cnt  <= cnt - 1'b1;
        pcnt <= '0;
      end else if (running) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assert_never_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  assert_step_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_step |=> (cnt == $past(cnt) - 1'b1));

  assert_zero_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> pulse);

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !pulse);

  assert_early_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && kick_evt && cnt > window_q) |=> pulse);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = COUNT_W,
  parameter int KW = KEY_W,
  parameter int AW = ADDR_W
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [KW-1:0] bus_wdata,
  output logic [KW-1:0] bus_rdata,
  input  logic          slow_clk,
  input  logic          slow_rst_n,
  output logic          wdt_rst_pulse
);
  localparam int FWD_W = N_FIELDS + 2;

  logic [N_FIELDS-1:0] req_t, ack_t, ack_lvl;
  logic run_t, kick_t;
  logic [SW-1:0] sel_sh;
  logic [CW-1:0] reload_sh, window_sh;
  logic [FWD_W-1:0] fwd_lvl;

  wdt_bus_if #(.SW(SW), .CW(CW), .KW(KW), .AW(AW)) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack_lvl(ack_lvl),
    .req_t(req_t), .run_t(run_t), .kick_t(kick_t),
    .sel_sh(sel_sh), .reload_sh(reload_sh), .window_sh(window_sh)
  );

  wdt_tsync #(.W(FWD_W)) u_fwd_sync (
    .clk(slow_clk), .rst_n(slow_rst_n),
    .d({kick_t, run_t, req_t}), .lvl(fwd_lvl)
  );

  wdt_slow_core #(.SW(SW), .CW(CW)) u_core (
    .clk(slow_clk), .rst_n(slow_rst_n),
    .req_lvl(fwd_lvl[N_FIELDS-1:0]),
    .run_lvl(fwd_lvl[N_FIELDS]), .kick_lvl(fwd_lvl[N_FIELDS+1]),
    .sel_d(sel_sh), .reload_d(reload_sh), .window_d(window_sh),
    .ack_t(ack_t), .pulse(wdt_rst_pulse)
  );

  wdt_tsync #(.W(N_FIELDS)) u_back_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_t), .lvl(ack_lvl)
  );
endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/100ps
module test_keyed_wdt;
  logic bus_clk = 0, slow_clk = 0;
  logic bus_rst_n = 0, slow_rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic wdt_rst_pulse;

  int n_tests = 0, n_fail = 0;
  int bus_cycles = 0;
  int scnt = 0, last_at = 0, pulses = 0, last_gap = 0, hi_run = 0, max_hi = 0;

  always #5 bus_clk = ~bus_clk;
  always #18.5 slow_clk = ~slow_clk;

  keyed_wdt i_keyed_wdt (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .wdt_rst_pulse(wdt_rst_pulse)
  );

  // pulse monitor, sampled mid slow cycle
  always @(negedge slow_clk) begin
    scnt <= scnt + 1;
    if (wdt_rst_pulse) begin
      if (hi_run == 0) begin
        pulses   <= pulses + 1;
        last_gap <= scnt - last_at;
        last_at  <= scnt;
      end
      hi_run <= hi_run + 1;
      if (hi_run + 1 > max_hi) max_hi <= hi_run + 1;
    end else begin
      hi_run <= 0;
    end
  end

  always @(posedge bus_clk) begin
    bus_cycles <= bus_cycles + 1;
    if (bus_cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 150000", bus_cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge bus_clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_idle(output int ok);
    int v;
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      rd(3'd4, v);
      if (v == 0) begin ok = 1; break; end
      @(negedge bus_clk);
    end
  endtask

  task automatic do_reset();
    bus_rst_n = 0; slow_rst_n = 0;
    idle(4);
    @(negedge slow_clk);
    bus_rst_n = 1; slow_rst_n = 1;
    idle(4);
  endtask

  task automatic setup_and_run(input int sel, input int rel, input int win);
    int ok;
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'(sel));
    wr(3'd2, 16'(rel));
    wr(3'd3, 16'(win));
    wait_idle(ok);
    wr(3'd0, 16'hCCCC);
  endtask

  task automatic wait_pulses(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (pulses >= target) break;
      @(negedge bus_clk);
    end
  endtask

  initial begin
    int v, ok, base, expv;
    do_reset();

    // R1 reset state
    rd(3'd1, v); check("R1", v, 0, "divider select after reset");
    rd(3'd2, v); check("R1", v, 4095, "reload after reset");
    rd(3'd3, v); check("R1", v, 4095, "window after reset");
    rd(3'd4, v); check("R1", v, 0, "status after reset");
    rd(3'd0, v); check("R1", v, 0, "key readback");
    idle(200);
    check("R1", pulses, 0, "pulses after reset");

    // R2 locked writes
    wr(3'd2, 16'h0123); rd(3'd2, v); check("R2", v, 4095, "reload write while locked");
    wr(3'd1, 16'h0005); rd(3'd1, v); check("R2", v, 0, "select write while locked");

    // R3 unlock and masked fields
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'h00FD); rd(3'd1, v); check("R3", v, 5, "select masked to 3 bits");
    wr(3'd2, 16'hABCD); rd(3'd2, v); check("R3", v, 16'h0BCD, "reload masked to 12 bits");

    // R4 busy bit behaviour (window write, bit 2)
    wait_idle(ok);
    wr(3'd3, 16'h0F00);
    rd(3'd4, v); check("R4", v, 4, "window busy right after write");
    // R5 write while busy is ignored
    wr(3'd3, 16'h0011);
    wait_idle(ok); check("R4", ok, 1, "status clears after handshake");
    rd(3'd3, v); check("R5", v, 16'h0F00, "window keeps pending value");
    wr(3'd2, 16'h0042);
    rd(3'd4, v); check("R4", v, 2, "reload busy bit position");
    wait_idle(ok);
    wr(3'd1, 16'h0002);
    rd(3'd4, v); check("R4", v, 1, "select busy bit position");
    wait_idle(ok);

    // R2 stray key relocks
    wr(3'd0, 16'h1234);
    wr(3'd3, 16'h0010); rd(3'd3, v); check("R2", v, 16'h0F00, "write after stray key");

    // R11 refresh before start
    base = pulses;
    wr(3'd0, 16'hAAAA);
    idle(3000);
    check("R11", pulses - base, 0, "refresh before start");

    // R6 start and relock; R8 refresh keeps quiet
    do_reset();
    setup_and_run(0, 20, 4095);
    wr(3'd2, 16'h0007); rd(3'd2, v); check("R6", v, 20, "reload locked after start");
    base = pulses;
    for (int i = 0; i < 30; i++) begin
      idle(100);
      wr(3'd0, 16'hAAAA);
    end
    check("R8", pulses - base, 0, "regular refresh prevents pulse");
    wr(3'd0, 16'h0BAD);
    wait_pulses(base + 2, 20000);
    check("R10", pulses - base, 2, "counter runs on after stray key");
    check("R7", last_gap, 84, "period reload 20 select 0");

    // R9 early refresh above window
    do_reset();
    setup_and_run(0, 100, 50);
    idle(200);
    base = pulses;
    wr(3'd0, 16'hAAAA);
    idle(60);
    check("R9", pulses - base, 1, "refresh above window fires");
    do_reset();
    setup_and_run(0, 100, 50);
    idle(1200);
    base = pulses;
    wr(3'd0, 16'hAAAA);
    idle(60);
    check("R9", pulses - base, 0, "refresh inside window accepted");

    // R7 sweep over divider select and small reload values
    for (int s = 0; s < 8; s++) begin
      for (int r = 0; r < 2; r++) begin
        do_reset();
        setup_and_run(s, r, 4095);
        base = pulses;
        expv = (r + 1) * (4 << s);
        wait_pulses(base + 2, expv * 12 + 400);
        check("R7", last_gap, expv, $sformatf("period select %0d reload %0d", s, r));
      end
    end
    for (int r = 3; r < 16; r += 4) begin
      do_reset();
      setup_and_run(1, r, 4095);
      base = pulses;
      expv = (r + 1) * 8;
      wait_pulses(base + 2, expv * 12 + 400);
      check("R7", last_gap, expv, $sformatf("period select 1 reload %0d", r));
    end
    check("R7", max_hi, 1, "pulse width in slow cycles");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule